// File: doc/BRIEF.md
# Static Decode-Stage Branch Predictor

This block sits in the decode stage of a pipelined processor. It looks at each instruction as it is accepted, recognises direct branches, and applies a fixed prediction rule that depends only on the instruction bits. An unconditional direct branch is always predicted taken. A conditional direct branch is predicted taken only when its displacement points backward. A branch that takes its target from a register is never predicted taken, because no target is known at decode. For a predicted-taken branch the block computes the target and, one cycle later, raises a combined flush-and-redirect pulse toward fetch and the instruction cache.

Each instruction is passed downstream one cycle after acceptance, together with its prediction bit. When the execute stage resolves a branch, it feeds back the prediction that travelled with it and the real outcome. The block raises a correction redirect only when the two differ. The correction goes to the resolved target if the branch was really taken, and to the next sequential address if it was not. A correction in the same cycle as a decode-stage prediction wins and discards the instruction in decode.

Instruction fields: the opcode is `insn[31:26]`. Opcode 0x31 is an unconditional direct branch with a signed word displacement in `insn[25:2]`. Opcode 0x32 is a conditional direct branch with a signed word displacement in `insn[15:2]`; `insn[25:16]` holds condition fields that this block ignores. Opcode 0x33 is a register-indirect branch. `insn[1]` is the absolute-address flag. Every other opcode is not a branch.

Top module: `bp_predict`

## Requirements
- R1: A valid instruction with opcode 0x31 is always predicted taken, whatever its displacement sign.
- R2: A valid instruction with opcode 0x32 is predicted taken exactly when its displacement sign bit `insn[15]` is 1. The field `insn[25:16]` has no effect on the prediction.
- R3: Opcode 0x33 and every opcode other than 0x31 and 0x32 are predicted not taken, and they raise no redirect.
- R4: The predicted target is found as follows. First append two zero bits to the displacement field and sign-extend the result to ADDR_W bits. If `insn[1]` is 1, this value is the target. Otherwise the target is the instruction address plus this value, modulo 2^ADDR_W.
- R5: An instruction predicted taken at acceptance edge N makes `redirect_o` high after edge N, with `redir_fix_o` low and `target_o` equal to the predicted target. This is a single-cycle pulse: `redirect_o` is low after edge N+1 when nothing new requests it.
- R6: One cycle after acceptance, the instruction, its address and its prediction bit appear on the `out_*` ports. `out_valid_o` stays 1 even when the instruction raised a redirect.
- R7: A resolved branch with `exe_valid_i` high raises a correction only when `exe_taken_i` differs from `exe_pred_taken_i`. A branch whose prediction matches raises nothing, and so does a mismatch while `exe_valid_i` is low.
- R8: A correction drives `redirect_o` and `redir_fix_o` high for one cycle. Its target is `exe_target_i` when the branch was really taken, and `exe_pc_i + 4` (modulo 2^ADDR_W) when it was not.
- R9: When a correction and a decode-stage acceptance fall in the same cycle, the correction's redirect and target win. The decode instruction is dropped: `out_valid_o` is 0 and `out_pred_taken_o` is 0.
- R10: During and right after reset, `out_valid_o`, `out_pred_taken_o`, `redirect_o`, `redir_fix_o` and `target_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dec_valid_i | input | 1 | Decode-stage instruction valid |
| dec_insn_i | input | 32 | Decode-stage instruction word |
| dec_pc_i | input | ADDR_W | Address of the decode-stage instruction |
| exe_valid_i | input | 1 | Execute stage has a resolved branch |
| exe_pred_taken_i | input | 1 | Prediction bit carried with the resolved branch |
| exe_taken_i | input | 1 | Actual outcome of the resolved branch |
| exe_pc_i | input | ADDR_W | Address of the resolved branch |
| exe_target_i | input | ADDR_W | Resolved branch target |
| out_valid_o | output | 1 | Downstream instruction valid |
| out_insn_o | output | 32 | Downstream instruction word |
| out_pc_o | output | ADDR_W | Downstream instruction address |
| out_pred_taken_o | output | 1 | Prediction bit sent downstream |
| redirect_o | output | 1 | Upstream flush and redirect pulse |
| redir_fix_o | output | 1 | Redirect is a misprediction correction |
| target_o | output | ADDR_W | Upstream redirect address |

## Verification
The decode sweep covers every branch opcode and some non-branch ones. Each is tried with zero, smallest, largest, and positive and negative displacements, in both the relative and the absolute form, at several instruction addresses, one of them near the top of the address space. This separates a sign test on the wrong bit, a missing shift or sign extension, and a missed wraparound. The execute sweep covers all four pairings of predicted and actual direction, a mismatch with the valid bit low, and an address whose sequential successor wraps to zero. This shows whether the correction fires on the right pairing and goes to the right target. A final collision case sends a predicted-taken branch into decode in the same cycle as a correction, to confirm which one wins.

// File: rtl/bp_pkg.sv
package bp_pkg;
  localparam int unsigned INSN_W = 32;
  localparam int unsigned OPC_W = 6;
  localparam int unsigned LDISP_W = 24;  // unconditional displacement, words
  localparam int unsigned SDISP_W = 14;  // conditional displacement, words
  localparam int unsigned LOFF_W = LDISP_W + 2;
  localparam int unsigned SOFF_W = SDISP_W + 2;

  localparam logic [OPC_W-1:0] OPC_JMP  = 6'h31;
  localparam logic [OPC_W-1:0] OPC_CJMP = 6'h32;
  localparam logic [OPC_W-1:0] OPC_RJMP = 6'h33;

  typedef enum logic [1:0] {
    BK_NONE,
    BK_JMP,
    BK_CJMP,
    BK_RJMP
  } br_kind_e;
endpackage

// File: rtl/bp_classify.sv
module bp_classify
  import bp_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [INSN_W-1:0] insn_i,
  output br_kind_e          kind_o,
  output logic              pred_o,
  output logic              abs_o,
  output logic [ADDR_W-1:0] offset_o
);
  localparam int unsigned LPAD = ADDR_W - LOFF_W;
  localparam int unsigned SPAD = ADDR_W - SOFF_W;

  logic [OPC_W-1:0]  opc;
  logic [ADDR_W-1:0] loff;
  logic [ADDR_W-1:0] soff;
  logic              unused_bit0;

  assign opc = insn_i[INSN_W-1 -: OPC_W];
  assign unused_bit0 = insn_i[0];
  assign abs_o = insn_i[1];

  // sign-extended byte offsets for both direct formats
  assign loff = {{LPAD{insn_i[LDISP_W+1]}}, insn_i[LDISP_W+1:2], 2'b00};
  assign soff = {{SPAD{insn_i[SDISP_W+1]}}, insn_i[SDISP_W+1:2], 2'b00};

  always_comb begin
    kind_o   = BK_NONE;
    pred_o   = 1'b0;
    offset_o = '0;
    case (opc)
      OPC_JMP: begin
        kind_o   = BK_JMP;
        pred_o   = 1'b1;
        offset_o = loff;
      end
      OPC_CJMP: begin
        kind_o   = BK_CJMP;
        pred_o   = insn_i[SDISP_W+1];  // backward taken
        offset_o = soff;
      end
      OPC_RJMP: begin
        kind_o = BK_RJMP;
        pred_o = 1'b0;  // no target known at decode
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/bp_target.sv
module bp_target #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] offset_i,
  input  logic              abs_i,
  output logic [ADDR_W-1:0] target_o
);
  assign target_o = abs_i ? offset_i : pc_i + offset_i;
endmodule

// File: rtl/bp_resolve.sv
module bp_resolve #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              valid_i,
  input  logic              pred_taken_i,
  input  logic              taken_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] target_i,
  output logic              miss_o,
  output logic [ADDR_W-1:0] fix_target_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

  assign miss_o = valid_i & (pred_taken_i ^ taken_i);
  assign fix_target_o = taken_i ? target_i : pc_i + STEP;
endmodule

// File: rtl/bp_predict.sv
module bp_predict
  import bp_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dec_valid_i,
  input  logic [INSN_W-1:0] dec_insn_i,
  input  logic [ADDR_W-1:0] dec_pc_i,
  input  logic              exe_valid_i,
  input  logic              exe_pred_taken_i,
  input  logic              exe_taken_i,
  input  logic [ADDR_W-1:0] exe_pc_i,
  input  logic [ADDR_W-1:0] exe_target_i,
  output logic              out_valid_o,
  output logic [INSN_W-1:0] out_insn_o,
  output logic [ADDR_W-1:0] out_pc_o,
  output logic              out_pred_taken_o,
  output logic              redirect_o,
  output logic              redir_fix_o,
  output logic [ADDR_W-1:0] target_o
);
  br_kind_e          kind;
  logic              pred;
  logic              abs_f;
  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] pred_tgt;
  logic              miss;
  logic [ADDR_W-1:0] fix_tgt;
  logic              dec_take;
  logic              unused_kind;

  logic              out_valid_q;
  logic [INSN_W-1:0] out_insn_q;
  logic [ADDR_W-1:0] out_pc_q;
  logic              out_pred_q;
  logic              redir_q;
  logic              fix_q;
  logic [ADDR_W-1:0] tgt_q;

  bp_classify #(.ADDR_W(ADDR_W)) u_cls (
    .insn_i   (dec_insn_i),
    .kind_o   (kind),
    .pred_o   (pred),
    .abs_o    (abs_f),
    .offset_o (offset)
  );

  bp_target #(.ADDR_W(ADDR_W)) u_tgt (
    .pc_i     (dec_pc_i),
    .offset_i (offset),
    .abs_i    (abs_f),
    .target_o (pred_tgt)
  );

  bp_resolve #(.ADDR_W(ADDR_W)) u_res (
    .valid_i      (exe_valid_i),
    .pred_taken_i (exe_pred_taken_i),
    .taken_i      (exe_taken_i),
    .pc_i         (exe_pc_i),
    .target_i     (exe_target_i),
    .miss_o       (miss),
    .fix_target_o (fix_tgt)
  );

  assign unused_kind = ^kind;
  // execute correction overrides the decode prediction
  assign dec_take = dec_valid_i & pred & ~miss;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_q <= 1'b0;
      out_insn_q  <= '0;
      out_pc_q    <= '0;
      out_pred_q  <= 1'b0;
      redir_q     <= 1'b0;
      fix_q       <= 1'b0;
      tgt_q       <= '0;
    end else begin
      out_valid_q <= dec_valid_i & ~miss;
      out_insn_q  <= dec_insn_i;
      out_pc_q    <= dec_pc_i;
      out_pred_q  <= dec_take;
      redir_q     <= miss | dec_take;
      fix_q       <= miss;
      if (miss)          tgt_q <= fix_tgt;
      else if (dec_take) tgt_q <= pred_tgt;
      else               tgt_q <= '0;
    end
  end

  assign out_valid_o      = out_valid_q;
  assign out_insn_o       = out_insn_q;
  assign out_pc_o         = out_pc_q;
  assign out_pred_taken_o = out_pred_q;
  assign redirect_o       = redir_q;
  assign redir_fix_o      = fix_q;
  assign target_o         = tgt_q;
endmodule

// File: rtl/bp_check.sv
module bp_check
  import bp_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              out_valid_i,
  input logic [OPC_W-1:0]  out_opc_i,
  input logic              out_sign_i,
  input logic              out_pred_i,
  input logic              redirect_i,
  input logic              fix_i,
  input logic [ADDR_W-1:0] target_i,
  input logic              exe_valid_i,
  input logic              exe_pred_i,
  input logic              exe_taken_i,
  input logic [ADDR_W-1:0] exe_pc_i
);
  AST_UNCOND_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_i && out_opc_i == OPC_JMP) |-> out_pred_i);  // R1

  AST_COND_BACKWARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_i && out_opc_i == OPC_CJMP) |-> (out_pred_i == out_sign_i));  // R2

  AST_OTHER_NOT_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_opc_i != OPC_JMP && out_opc_i != OPC_CJMP) |-> !out_pred_i);  // R3

  AST_PRED_REDIRECTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_i && out_pred_i) |-> (redirect_i && !fix_i));  // R5

  AST_MISS_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(exe_valid_i && (exe_pred_i != exe_taken_i)) |->
      (redirect_i && fix_i && !out_valid_i));  // R9

  AST_REDIRECT_CAUSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_i |-> ((out_valid_i && out_pred_i) ||
                    $past(exe_valid_i && (exe_pred_i != exe_taken_i))));  // R7

  AST_SEQ_FIX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(exe_valid_i && exe_pred_i && !exe_taken_i) |->
      (target_i == $past(exe_pc_i) + ADDR_W'(4)));  // R8
endmodule

bind bp_predict bp_check #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .out_valid_i (out_valid_o),
  .out_opc_i   (out_insn_o[31:26]),
  .out_sign_i  (out_insn_o[15]),
  .out_pred_i  (out_pred_taken_o),
  .redirect_i  (redirect_o),
  .fix_i       (redir_fix_o),
  .target_i    (target_o),
  .exe_valid_i (exe_valid_i),
  .exe_pred_i  (exe_pred_taken_i),
  .exe_taken_i (exe_taken_i),
  .exe_pc_i    (exe_pc_i)
);

// File: tb/tb_bp_predict.sv
`timescale 1ns/1ps
module tb_bp_predict;
  localparam int unsigned AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          dec_valid = 1'b0;
  logic [31:0]   dec_insn = '0;
  logic [AW-1:0] dec_pc = '0;
  logic          exe_valid = 1'b0;
  logic          exe_pred = 1'b0;
  logic          exe_taken = 1'b0;
  logic [AW-1:0] exe_pc = '0;
  logic [AW-1:0] exe_tgt = '0;
  logic          out_valid;
  logic [31:0]   out_insn;
  logic [AW-1:0] out_pc;
  logic          out_pred;
  logic          redirect;
  logic          fix;
  logic [AW-1:0] target;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bp_predict #(.ADDR_W(AW)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .dec_valid_i(dec_valid), .dec_insn_i(dec_insn), .dec_pc_i(dec_pc),
    .exe_valid_i(exe_valid), .exe_pred_taken_i(exe_pred), .exe_taken_i(exe_taken),
    .exe_pc_i(exe_pc), .exe_target_i(exe_tgt),
    .out_valid_o(out_valid), .out_insn_o(out_insn), .out_pc_o(out_pc),
    .out_pred_taken_o(out_pred), .redirect_o(redirect), .redir_fix_o(fix),
    .target_o(target)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic dec_case(input logic [5:0] opc, input int off, input bit ab,
                          input logic [AW-1:0] pc);
    logic [31:0]   offs;
    logic [31:0]   insn;
    logic [AW-1:0] exp_t;
    bit            exp_p;
    string         rq;
    offs = off;
    if (opc == 6'h32) insn = {opc, 10'h2a5, offs[15:2], ab, 1'b0};
    else              insn = {opc, offs[25:2], ab, 1'b0};
    exp_p = (opc == 6'h31) ? 1'b1 : (opc == 6'h32) ? (off < 0) : 1'b0;
    rq = (opc == 6'h31) ? "R1" : (opc == 6'h32) ? "R2" : "R3";
    exp_t = ab ? offs : pc + offs;
    @(negedge clk);
    dec_valid = 1'b1; dec_insn = insn; dec_pc = pc;
    @(negedge clk);
    dec_valid = 1'b0;
    chk("R6 valid", 64'(out_valid), 64'd1);
    chk("R6 pc", 64'(out_pc), 64'(pc));
    chk("R6 insn", 64'(out_insn), 64'(insn));
    chk(rq, 64'(out_pred), 64'(exp_p));
    chk("R5 redirect", 64'(redirect), 64'(exp_p));
    if (exp_p) begin
      chk("R4 target", 64'(target), 64'(exp_t));
      chk("R5 fix low", 64'(fix), 64'd0);
    end
    @(negedge clk);
    chk("R5 pulse", 64'(redirect), 64'd0);
  endtask

  task automatic exe_case(input bit v, input bit p, input bit t,
                          input logic [AW-1:0] pc, input logic [AW-1:0] tg);
    bit            exp_r;
    logic [AW-1:0] exp_t;
    exp_r = v && (p != t);
    exp_t = t ? tg : pc + 32'd4;
    @(negedge clk);
    exe_valid = v; exe_pred = p; exe_taken = t; exe_pc = pc; exe_tgt = tg;
    @(negedge clk);
    exe_valid = 1'b0;
    chk("R7 redirect", 64'(redirect), 64'(exp_r));
    if (exp_r) begin
      chk("R8 fix", 64'(fix), 64'd1);
      chk("R8 target", 64'(target), 64'(exp_t));
    end
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int offs_l[8];
    int offs_s[6];
    logic [AW-1:0] pcs[3];
    logic [5:0] opcs[5];
    offs_l = '{0, 4, -4, 33554428, -33554432, 4096, -1048576, 1024};
    offs_s = '{0, 4, -4, 32764, -32768, -256};
    pcs = '{32'h0000_1000, 32'h8000_0000, 32'hFFFF_FF00};
    opcs = '{6'h31, 6'h32, 6'h33, 6'h00, 6'h30};

    #1;
    chk("R10 valid", 64'(out_valid), 64'd0);
    chk("R10 redirect", 64'(redirect), 64'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 valid", 64'(out_valid), 64'd0);
    chk("R10 pred", 64'(out_pred), 64'd0);
    chk("R10 redirect", 64'(redirect), 64'd0);
    chk("R10 fix", 64'(fix), 64'd0);
    chk("R10 target", 64'(target), 64'd0);

    foreach (opcs[o]) begin
      foreach (pcs[k]) begin
        for (int a = 0; a < 2; a++) begin
          if (opcs[o] == 6'h32) begin
            foreach (offs_s[i]) dec_case(opcs[o], offs_s[i], a[0], pcs[k]);
          end else begin
            foreach (offs_l[i]) dec_case(opcs[o], offs_l[i], a[0], pcs[k]);
          end
        end
      end
    end

    for (int v = 0; v < 2; v++)
      for (int p = 0; p < 2; p++)
        for (int t = 0; t < 2; t++)
          exe_case(v[0], p[0], t[0], 32'h1000_0040 + 32'(p * 16), 32'h2000_0100 + 32'(t * 8));
    exe_case(1'b1, 1'b1, 1'b0, 32'hFFFF_FFFC, 32'h0);  // R8 wraps to zero

    // R9: correction collides with a predicted-taken decode
    @(negedge clk);
    dec_valid = 1'b1; dec_insn = {6'h31, 24'h000010, 2'b00}; dec_pc = 32'h0000_4000;
    exe_valid = 1'b1; exe_pred = 1'b0; exe_taken = 1'b1;
    exe_pc = 32'h0000_3000; exe_tgt = 32'h0000_7770;
    @(negedge clk);
    dec_valid = 1'b0; exe_valid = 1'b0;
    chk("R9 valid", 64'(out_valid), 64'd0);
    chk("R9 pred", 64'(out_pred), 64'd0);
    chk("R9 redirect", 64'(redirect), 64'd1);
    chk("R9 fix", 64'(fix), 64'd1);
    chk("R9 target", 64'(target), 64'h7770);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule